// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block turns eight raw interrupt request lines into a single interrupt output and the index of the line that should be serviced next. Each line is captured into a request register on the rising clock edge. A per-line trigger-select register chooses how the line is captured. In level mode the request bit follows the line. In edge mode the request bit is set on a rising transition and then stays set.

The captured requests are gated by a mask. The surviving requests are ranked against a programmable rotation base, so the highest priority can be moved to any line. The best pending request is compared with the best in-service request, which the surrounding controller supplies. The output is raised only when the pending request strictly outranks everything in service.

The block is built in two flavours, selected by a parameter: a primary instance and a secondary instance. They differ in which trigger-select bits may be set. On the primary, a nested mode can also leave the cascade line out of the in-service comparison.

Top module: `pic_resolver`

## Requirements
- R1: A line whose trigger-select bit is 1 (level mode) has a request bit equal to the line level sampled at the latest rising clock edge.
- R2: A line whose trigger-select bit is 0 (edge mode) sets its request bit when it is sampled high after having been sampled low at the previous edge. A falling line never clears the request bit. The sampled history follows the line in both modes.
- R3: Only requests whose mask bit is 0 take part. With no unmasked request, `int_out` is 0.
- R4: Line i has rank (i - prio_base) mod 8, and rank 0 is the highest. The winner is the unmasked request with the smallest rank, and `win_idx` is (rank + prio_base) mod 8.
- R5: `int_out` is 1 only if the best pending rank is strictly smaller than the best rank among the `in_service` bits. An empty set counts as rank 8, and equal ranks give 0.
- R6: On the primary instance (IS_PRIMARY=1) with `nested_en`=1, `in_service` bit 2 is left out of the in-service rank. On the secondary instance, `nested_en` has no effect.
- R7: When `trig_wr_en` is high at a rising edge, the trigger-select register loads `trig_wr_data` ANDed with a fixed writable mask: 0xF8 on the primary and 0xDE on the secondary. Non-writable bits become 0 (edge mode).
- R8: While `rst_n` is low, the request, history and trigger-select registers are 0, and `int_out` and `win_idx` are 0.
- R9: A change on `irq_lines` affects the outputs only after the next rising edge. Changes on `irq_mask`, `in_service`, `prio_base` and `nested_en` affect them in the same cycle.
- R10: `win_idx` is 0 whenever `int_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_lines | input | 8 | Raw interrupt request lines |
| irq_mask | input | 8 | 1 = request on that line is blocked |
| in_service | input | 8 | Lines currently being serviced |
| prio_base | input | 3 | Line that holds rank 0 |
| nested_en | input | 1 | Nested mode: leave cascade line out of in-service rank (primary only) |
| trig_wr_en | input | 1 | Load enable for the trigger-select register |
| trig_wr_data | input | 8 | New trigger-select value, 1 = level, 0 = edge |
| int_out | output | 1 | Interrupt request toward the processor |
| win_idx | output | 3 | Index of the winning line, 0 when `int_out` is 0 |

## Verification
A line change reaches the outputs one clock edge later, because exactly one register, the request register, sits on that path. The bench therefore drives lines between edges, updates its arithmetic model of the request register at the edge, and samples 2 ns after it. It also checks before that edge that nothing has moved yet. Mask, in-service, base and nested-mode changes go through the resolver only. Those sweeps change the inputs and compare 1 ns later, without waiting for a clock. Trigger-select writes take effect at the same edge that loads them, but they only change how the line is captured from the following edge on.

// File: rtl/pic_res_pkg.sv
package pic_res_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned IDX_W  = $clog2(NLINES);
  localparam int unsigned RANK_W = IDX_W + 1;
  localparam logic [NLINES-1:0] PRIMARY_WMASK   = 8'hF8;
  localparam logic [NLINES-1:0] SECONDARY_WMASK = 8'hDE;
  localparam int unsigned CASCADE_LINE = 2;

  typedef logic [NLINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0]  line_idx_t;
  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture
  import pic_res_pkg::*;
#(
  parameter line_vec_t WMASK = PRIMARY_WMASK
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lines,
  input  logic      trig_wr_en,
  input  line_vec_t trig_wr_data,
  output line_vec_t req_q,
  output line_vec_t trig_q
);
  line_vec_t hist_q;
  line_vec_t req_d, hist_d, trig_d;

  // Next-state: capture according to per-line trigger mode
  always_comb begin
    for (int i = 0; i < int'(NLINES); i++) begin
      if (trig_q[i]) req_d[i] = lines[i];
      else           req_d[i] = req_q[i] | (lines[i] & ~hist_q[i]);
    end
    hist_d = lines;
    trig_d = trig_q;
    if (trig_wr_en) trig_d = trig_wr_data & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      hist_q <= '0;
      trig_q <= '0;
    end else begin
      req_q  <= req_d;
      hist_q <= hist_d;
      trig_q <= trig_d;
    end
  end
endmodule

// File: rtl/pic_rank_find.sv
module pic_rank_find
  import pic_res_pkg::*;
(
  input  line_vec_t vec,
  input  line_idx_t base,
  output rank_t     rank
);
  line_vec_t rot;

  // Rotate so that bit k holds line (k + base) mod NLINES
  always_comb begin
    for (int k = 0; k < int'(NLINES); k++)
      rot[k] = vec[IDX_W'((k + int'(base)) % int'(NLINES))];
  end

  // Lowest set bit of rotated vector is the best rank; NLINES if empty
  always_comb begin
    rank = RANK_W'(NLINES);
    for (int k = int'(NLINES) - 1; k >= 0; k--)
      if (rot[k]) rank = RANK_W'(k);
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_res_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_lines,
  input  logic [7:0] irq_mask,
  input  logic [7:0] in_service,
  input  logic [2:0] prio_base,
  input  logic       nested_en,
  input  logic       trig_wr_en,
  input  logic [7:0] trig_wr_data,
  output logic       int_out,
  output logic [2:0] win_idx
);
  localparam line_vec_t WMASK    = IS_PRIMARY ? PRIMARY_WMASK : SECONDARY_WMASK;
  localparam line_vec_t CASC_BIT = IS_PRIMARY ? line_vec_t'(1 << CASCADE_LINE) : '0;

  line_vec_t req_q, trig_q;
  line_vec_t pend_vec, serv_vec;
  rank_t     pend_rank, serv_rank;

  pic_req_capture #(.WMASK(WMASK)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .lines        (irq_lines),
    .trig_wr_en   (trig_wr_en),
    .trig_wr_data (trig_wr_data),
    .req_q        (req_q),
    .trig_q       (trig_q)
  );

  always_comb begin
    pend_vec = req_q & ~irq_mask;
    serv_vec = in_service & ~(nested_en ? CASC_BIT : line_vec_t'(0));
  end

  pic_rank_find u_pend (.vec(pend_vec), .base(prio_base), .rank(pend_rank));
  pic_rank_find u_serv (.vec(serv_vec), .base(prio_base), .rank(serv_rank));

  always_comb begin
    int_out = (pend_rank < serv_rank);
    win_idx = '0;
    if (int_out)
      win_idx = IDX_W'((int'(pend_rank) + int'(prio_base)) % int'(NLINES));
  end
endmodule

// File: rtl/pic_resolver_chk.sv
module pic_resolver_chk
  import pic_res_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] irq_lines,
  input logic [7:0] req_q,
  input logic [7:0] trig_q,
  input logic [7:0] irq_mask,
  input logic [7:0] in_service,
  input logic       int_out,
  input logic [2:0] win_idx
);
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (req_q[win_idx] && !irq_mask[win_idx])); // R3
  AST_EMPTY_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~irq_mask) == 8'h00) |-> !int_out); // R3
  AST_WIN_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && win_idx != 3'd2) |-> !in_service[win_idx]); // R5
  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    !int_out |-> (win_idx == 3'd0)); // R10

  for (genvar g = 0; g < int'(NLINES); g++) begin : g_line
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q[g] |=> (req_q[g] == $past(irq_lines[g]))); // R1
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_q[g] && req_q[g]) |=> req_q[g]); // R2
  end
endmodule

bind pic_resolver pic_resolver_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_lines  (irq_lines),
  .req_q      (req_q),
  .trig_q     (trig_q),
  .irq_mask   (irq_mask),
  .in_service (in_service),
  .int_out    (int_out),
  .win_idx    (win_idx)
);

// File: tb/tb_pic_resolver.sv
`timescale 1ns/1ps
module tb_pic_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lines = '0, mask = '0, isr = '0, wdata = '0;
  logic [2:0] base = '0;
  logic       nest = 1'b0, wr_en = 1'b0;
  logic       int_p, int_s;
  logic [2:0] idx_p, idx_s;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  // reference state, primary and secondary
  logic [7:0] req_p = '0, hist_p = '0, trig_p = '0;
  logic [7:0] req_s = '0, hist_s = '0, trig_s = '0;

  always #5 clk = ~clk;

  pic_resolver #(.IS_PRIMARY(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .irq_mask(mask),
    .in_service(isr), .prio_base(base), .nested_en(nest),
    .trig_wr_en(wr_en), .trig_wr_data(wdata), .int_out(int_p), .win_idx(idx_p));

  pic_resolver #(.IS_PRIMARY(1'b0)) dut_sec (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .irq_mask(mask),
    .in_service(isr), .prio_base(base), .nested_en(nest),
    .trig_wr_en(wr_en), .trig_wr_data(wdata), .int_out(int_s), .win_idx(idx_s));

  function automatic logic [7:0] cap_next(logic [7:0] rq, logic [7:0] hs,
                                          logic [7:0] tg, logic [7:0] ln);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = tg[i] ? ln[i] : (rq[i] | (ln[i] & ~hs[i]));
    return r;
  endfunction

  function automatic int best_rank(logic [7:0] v, int b);
    for (int r = 0; r < 8; r++)
      if (v[(r + b) % 8]) return r;
    return 8;
  endfunction

  task automatic check_one(string tag, string who, logic [7:0] rq, bit primary,
                           logic got_int, logic [2:0] got_idx);
    logic [7:0] sv;
    int pr, sr;
    logic ei;
    logic [2:0] ex;
    sv = isr;
    if (primary && nest) sv[2] = 1'b0;
    pr = best_rank(rq & ~mask, int'(base));
    sr = best_rank(sv, int'(base));
    ei = (pr < sr);
    ex = ei ? 3'((pr + int'(base)) % 8) : 3'd0;
    checks++;
    if (got_int !== ei || got_idx !== ex) begin
      fails++;
      $display("FAIL %s %s: int=%0b idx=%0d expected int=%0b idx=%0d",
               tag, who, got_int, got_idx, ei, ex);
    end
  endtask

  task automatic check(string tag);
    check_one(tag, "primary", req_p, 1'b1, int_p, idx_p);
    check_one(tag, "secondary", req_s, 1'b0, int_s, idx_s);
  endtask

  // one clock edge; reference model updated from inputs present at the edge
  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      req_p = cap_next(req_p, hist_p, trig_p, lines); hist_p = lines;
      req_s = cap_next(req_s, hist_s, trig_s, lines); hist_s = lines;
      if (wr_en) begin trig_p = wdata & 8'hF8; trig_s = wdata & 8'hDE; end
    end
    #2;
  endtask

  task automatic do_reset(logic [7:0] ln);
    lines = ln; rst_n = 1'b0; wr_en = 1'b0; mask = '0; isr = '0; base = '0; nest = 1'b0;
    req_p = '0; hist_p = '0; trig_p = '0; req_s = '0; hist_s = '0; trig_s = '0;
    tick(); tick();
    check("R8");
    rst_n = 1'b1;
  endtask

  task automatic write_trig(logic [7:0] v);
    wdata = v; wr_en = 1'b1; tick(); wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    // reset holds history clear even with lines high: first edge is a rise
    do_reset(8'hFF);
    tick(); check("R2");

    // explicit edge: set on rise, falling keeps it
    do_reset(8'h00);
    lines = 8'h40; tick(); check("R2");
    lines = 8'h00; tick(); check("R2");

    // trigger write filtering: primary bit1 edge, secondary bit1 level
    do_reset(8'h00);
    write_trig(8'hFF);
    lines = 8'h02; #1 check("R9"); tick(); check("R7");
    lines = 8'h00; tick(); mask = 8'hFD; #1 check("R7");
    // level line on both: follows the line
    mask = 8'hEF; lines = 8'h10; #1 check("R9"); tick(); check("R1");
    lines = 8'h00; tick(); check("R1");

    // level sweep with edge-only lines hidden
    mask = 8'h27; lf = 8'hA5;
    for (int s = 0; s < 300; s++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      lines = lf; base = 3'(s % 8);
      tick(); check("R1");
    end

    // resolver sweeps with every request set
    do_reset(8'h00);
    lines = 8'hFF; tick(); check("R2");
    isr = '0;
    for (int m = 0; m < 256; m++)
      for (int b = 0; b < 8; b++) begin
        mask = 8'(m); base = 3'(b); #1 check("R4");
      end
    for (int mi = 0; mi < 3; mi++)
      for (int v = 0; v < 256; v++)
        for (int b = 0; b < 8; b++)
          for (int n = 0; n < 2; n++) begin
            mask = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h5A : 8'hFE;
            isr = 8'(v); base = 3'(b); nest = n[0]; #1 check("R5");
          end

    // strict comparison at equal rank
    nest = 1'b0; base = 3'd0; mask = 8'hF7;
    isr = 8'h08; #1 check("R5");
    isr = 8'h10; #1 check("R5");
    // cascade line excluded only on the primary
    isr = 8'h04; nest = 1'b1; #1 check("R6");
    nest = 1'b0; #1 check("R6");
    // everything masked
    mask = 8'hFF; isr = 8'h00; #1 check("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule